// File: doc/BRIEF.md
# Register-Mapped Integer Square Root

The block computes the floor of the square root of an unsigned integer held in a 64-bit parameter register. Software writes the parameter as two 32-bit words and a control word. Each of these writes starts a new computation. A status flag shows when the unit is working, and software reads the 32-bit result once that flag has cleared.

A control bit sets the width of the input. When the bit is clear, only the low 32 bits of the parameter are used. When it is set, all 64 bits are used. The datapath uses the power-of-four shift-and-subtract recurrence. It first seeds a trial bit at the largest power of four that does not exceed the input. It then resolves one result bit per clock.

Top module: `isqrt_mmio`

## Requirements
- R1: After reset, all four registers read zero and the busy flag is clear.
- R2: When control bit 0 is 0, the radicand is the low 32 bits of the parameter, and the high word has no effect on the result.
- R3: When control bit 0 is 1, the radicand is the full 64-bit parameter, with word 2 as bits 63:32.
- R4: Once busy is clear, the result register holds r such that r*r <= x < (r+1)*(r+1), where x is the radicand.
- R5: Busy reads back on control bit 15. It is high for exactly floor(m/2)+1 cycles after a starting write, where m is the index of the highest set bit of the radicand. That is at most 32 cycles. A zero radicand never sets busy.
- R6: A write to word 0, 1 or 2 restarts the computation from the updated register values, even if a computation is already running.
- R7: A write to word 3 changes nothing: the result, both parameter words and the control bit keep their values. Unused control bits read as zero.
- R8: The word addresses are fixed. Word 0 is control/status, word 1 is parameter bits 31:0, word 2 is parameter bits 63:32, and word 3 is the result. A read returns the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | 2 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The bench builds the block with its default 32-bit bus, so the radicand is 64 bits wide. This reaches the longest iteration of 32 cycles with an all-ones input and the widest perfect square, (2^32-1)^2. The narrow mode is tested with junk in the high word, so that the masking is seen in the result. A restart is issued halfway through a wide computation, and the busy length is measured against the highest-set-bit rule.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_P_LO  = 2'd1,
    SEL_P_HI  = 2'd2,
    SEL_ROOT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_WIDE_POS = 0;
  localparam int unsigned CTRL_BUSY_POS = 15;
endpackage

// File: rtl/isqrt_seed.sv
// Largest power of four not above x; zero when x is zero.
module isqrt_seed #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] bit_o
);
  localparam int unsigned PAIRS = W / 2;

  logic [PAIRS-1:0] pair_nz;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign pair_nz[k] = |x_i[2*k +: 2];
  end

  always_comb begin
    bit_o = '0;
    for (int k = 0; k < PAIRS; k++) begin
      if (pair_nz[k]) bit_o = W'(1) << (2 * k);
    end
  end
endmodule

// File: rtl/isqrt_step.sv
module isqrt_step #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] bit_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] trial;

  always_comb begin
    trial = acc_i + bit_i;
    if (rem_i >= trial) begin
      rem_o = rem_i - trial;
      acc_o = (acc_i >> 1) + bit_i;
    end else begin
      rem_o = rem_i;
      acc_o = acc_i >> 1;
    end
  end
endmodule

// File: rtl/isqrt_mmio.sv
module isqrt_mmio
  import isqrt_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o
);
  localparam int unsigned X_W   = 2 * BUS_W;
  localparam int unsigned RES_W = BUS_W;
  localparam int unsigned CNT_W = $clog2(RES_W + 1);

  logic             wide_q, wide_n;
  logic [BUS_W-1:0] p_lo_q, p_lo_n, p_hi_q, p_hi_n;
  logic [X_W-1:0]   x_n, seed;
  logic [X_W-1:0]   rem_q, acc_q, bit_q, rem_s, acc_s;
  logic             busy_q;
  logic             restart;

  assign restart = we_i && (addr_i != SEL_ROOT);
  assign wide_n  = (we_i && addr_i == SEL_CTRL) ? wdata_i[CTRL_WIDE_POS] : wide_q;
  assign p_lo_n  = (we_i && addr_i == SEL_P_LO) ? wdata_i : p_lo_q;
  assign p_hi_n  = (we_i && addr_i == SEL_P_HI) ? wdata_i : p_hi_q;
  assign x_n     = wide_n ? {p_hi_n, p_lo_n} : {{BUS_W{1'b0}}, p_lo_n};

  isqrt_seed #(.W(X_W)) u_seed (.x_i(x_n), .bit_o(seed));

  isqrt_step #(.W(X_W)) u_step (
    .rem_i(rem_q), .acc_i(acc_q), .bit_i(bit_q),
    .rem_o(rem_s), .acc_o(acc_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b0;
      p_lo_q <= '0;
      p_hi_q <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      wide_q <= wide_n;
      p_lo_q <= p_lo_n;
      p_hi_q <= p_hi_n;
      if (restart) begin
        rem_q  <= x_n;
        acc_q  <= '0;
        bit_q  <= seed;
        busy_q <= |seed;
      end else if (busy_q) begin
        rem_q  <= rem_s;
        acc_q  <= acc_s;
        bit_q  <= bit_q >> 2;
        busy_q <= !bit_q[0];  // trial bit of one is the last step
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      SEL_CTRL: begin
        rdata_o[CTRL_WIDE_POS] = wide_q;
        rdata_o[CTRL_BUSY_POS] = busy_q;
      end
      SEL_P_LO: rdata_o = p_lo_q;
      SEL_P_HI: rdata_o = p_hi_q;
      SEL_ROOT: rdata_o = acc_q[RES_W-1:0];
      default:  rdata_o = '0;
    endcase
  end

  // checking support
  logic [CNT_W-1:0] busy_cnt;
  logic [X_W-1:0]   x_cur;
  logic [X_W+1:0]   r_ext, lo_sq, hi_sq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= '0;
    else if (restart) busy_cnt <= '0;
    else if (busy_q)  busy_cnt <= busy_cnt + 1'b1;
  end

  assign x_cur = wide_q ? {p_hi_q, p_lo_q} : {{BUS_W{1'b0}}, p_lo_q};
  assign r_ext = (X_W + 2)'(acc_q[RES_W-1:0]);
  assign lo_sq = r_ext * r_ext;
  assign hi_sq = (r_ext + 1'b1) * (r_ext + 1'b1);

  a_r5_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (busy_cnt < CNT_W'(RES_W)));

  a_r5_trial_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bit_q));

  a_r5_busy_has_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (bit_q != '0));

  a_r4_root_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && !$past(restart)) |->
      (lo_sq <= (X_W + 2)'(x_cur)) && (hi_sq > (X_W + 2)'(x_cur)));

  a_r7_root_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_ROOT && !busy_q) |=>
      ($stable(p_lo_q) && $stable(p_hi_q) && $stable(wide_q) && $stable(acc_q)));
endmodule

// File: tb/tb_isqrt_mmio.sv
module tb_isqrt_mmio;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NV = 12;
  // {wide, radicand parameter, expected root}
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 64'h0000_0000_0000_0001, 32'd1},
    {1'b0, 64'h0000_0000_0000_0002, 32'd1},
    {1'b0, 64'h0000_0000_FFFF_FFFF, 32'd65535},
    {1'b0, 64'hDEAD_BEEF_0000_0010, 32'd4},
    {1'b0, 64'h0000_0000_3B9A_CA00, 32'd31622},
    {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF},
    {1'b1, 64'h0000_0001_0000_0000, 32'h0001_0000},
    {1'b1, 64'hFFFF_FFFE_0000_0001, 32'hFFFF_FFFF},
    {1'b1, 64'hFFFF_FFFE_0000_0000, 32'hFFFF_FFFE},
    {1'b1, 64'h0123_4567_89AB_CDEF, 32'h1111_1111},
    {1'b1, 64'h4000_0000_0000_0000, 32'h8000_0000},
    {1'b1, 64'h3FFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int fails = 0;

  isqrt_mmio dut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // counts cycles busy stays high, starting at the negedge after the write
  task automatic wait_idle(output int n);
    logic [31:0] c;
    n = 0;
    rd(2'd0, c);
    while (c[15] && n < 100) begin
      n++;
      @(negedge clk_i);
      rd(2'd0, c);
    end
  endtask

  task automatic load(input logic wide, input logic [63:0] x, output int n);
    wr(2'd1, x[31:0]);
    wr(2'd2, x[63:32]);
    wr(2'd0, {31'd0, wide});
    wait_idle(n);
  endtask

  function automatic logic root_ok(input logic [63:0] x, input logic [31:0] r);
    logic [65:0] rr, r1;
    rr = 66'(r) * 66'(r);
    r1 = (66'(r) + 66'd1) * (66'(r) + 66'd1);
    return (rr <= 66'(x)) && (r1 > 66'(x));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] lfsr;
    int n;
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state; R8 word map
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", 64'(d), 64'd0);
    end

    // R2/R3/R4 table
    for (int i = 0; i < NV; i++) begin
      load(VEC[i][96], VEC[i][95:32], n);
      rd(2'd3, d);
      chk(VEC[i][96] ? "R3 R4 wide root" : "R2 R4 narrow root", 64'(d), 64'(VEC[i][31:0]));
    end

    // R4 pseudo-random radicands, both widths
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 24; i++) begin
      logic [63:0] xm;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      lfsr = lfsr * 64'd6364136223846793005 + 64'd1442695040888963407;
      load(i[0], lfsr, n);
      xm = i[0] ? lfsr : {32'd0, lfsr[31:0]};
      rd(2'd3, d);
      checks++;
      if (!root_ok(xm, d)) begin
        fails++;
        $display("FAIL R4 random: actual %h for radicand %h expected floor root", d, xm);
      end
    end

    // R5 busy length
    load(1'b0, 64'h0000_0000_FFFF_FFFF, n);
    chk("R5 busy cycles narrow max", 64'(n), 64'd16);
    load(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, n);
    chk("R5 busy cycles wide max", 64'(n), 64'd32);
    load(1'b1, 64'h0000_0000_0000_0001, n);
    chk("R5 busy cycles one", 64'(n), 64'd1);
    load(1'b1, 64'h0000_0000_0000_0000, n);
    chk("R5 zero never busy", 64'(n), 64'd0);
    rd(2'd3, d);
    chk("R5 zero root", 64'(d), 64'd0);

    // R6 restart mid-run: wide all-ones, then switch to narrow
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'd1);
    @(negedge clk_i);
    @(negedge clk_i);
    rd(2'd0, d);
    chk("R6 busy before restart", 64'(d[15]), 64'd1);
    wr(2'd0, 32'd0);
    wait_idle(n);
    chk("R6 restart busy cycles", 64'(n), 64'd16);
    rd(2'd3, d);
    chk("R6 restart root", 64'(d), 64'd65535);

    // R7 result write inert, control readback
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, d);
    chk("R7 root after write", 64'(d), 64'd65535);
    rd(2'd1, d);
    chk("R7 param lo kept", 64'(d), 64'hFFFF_FFFF);
    rd(2'd2, d);
    chk("R7 param hi kept", 64'(d), 64'hFFFF_FFFF);
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk_i);
    rd(2'd0, d);
    chk("R7 R8 ctrl readback while busy", 64'(d), 64'h0000_8001);
    wait_idle(n);
    rd(2'd0, d);
    chk("R8 ctrl idle readback", 64'(d), 64'h0000_0001);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule